// File: doc/BRIEF.md
# TDM Serial Input Bit-Delay and Fractional Sampler

This block receives one serial time-division-multiplexed input stream and turns it back into channel bytes. A frame holds `NUM_CHANNELS` channels of eight bit cells each. The most significant bit of each channel arrives first. A clock running at four times the bit rate divides every bit cell into four oversampling cycles. A frame pulse marks the first oversampling cycle of the frame.

Software sets the stream's timing through a control word. A 3-bit field moves the capture window of every channel later by 0 to 7 whole bit cells. A 2-bit field picks which quarter of each bit cell is sampled. The quarter codes do not follow a binary order.

In the fast line-rate mode only two quarter positions are legal. A write that asks for either of the other two is refused, and a flag reports the refusal. Each recovered byte is presented with its channel number and a one-cycle valid strobe.

Top module: `tdm_in_sampler`

## Requirements
- R1: After reset `byteValid` and `cfgErr` are 0, the whole-bit delay is 0 and the sampling code is `00`, so the design behaves as if no write had been made.
- R2: The four oversampling cycles of a bit cell are numbered 0 to 3 from the start of the cell. The cycle in which `framePulse` is high is cycle 0 of bit cell 0 of the frame. `sdIn` is captured at the rising edge that ends the selected cycle. Code `01` selects cycle 0, `10` selects cycle 1, `00` selects cycle 2 and `11` selects cycle 3.
- R3: With whole-bit delay d, channel c is built from frame bit cells c*8+d through c*8+d+7. The first of these cells becomes bit 7 of `byteOut` and the last becomes bit 0.
- R4: Cell positions that pass the end of the frame wrap into the next frame. With d > 0, the last channel of a frame takes its final bits from the first cells after the next frame pulse.
- R5: `byteValid` is high for exactly the one clock cycle that follows the rising edge that sampled a channel's last bit. It pulses once per channel, and `chanOut` then carries that channel's index, 0 to `NUM_CHANNELS`-1.
- R6: No byte is presented before the first `framePulse` after reset. The first byte presented is channel 0, because an output is made only for a window whose first bit was sampled after that pulse.
- R7: When `fastMode` is 1, a write (`ctrlWr` high) whose sampling code (`ctrlWord[5:4]`) is `01` or `00` sets `cfgErr` to 1 on the next cycle. Such a write changes neither the delay nor the sampling code in use.
- R8: Any other write loads the delay from `ctrlWord[8:6]` and the sampling code from `ctrlWord[5:4]`, and clears `cfgErr` on the next cycle. All other bits of `ctrlWord` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, four cycles per bit cell |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulse | input | 1 | High in the first oversampling cycle of a frame |
| sdIn | input | 1 | Serial TDM data |
| ctrlWr | input | 1 | Write strobe for the control word |
| ctrlWord | input | CTRL_W | Control word: delay in bits 8:6, sampling code in bits 5:4 |
| fastMode | input | 1 | Fast line-rate mode; restricts the legal sampling codes |
| byteOut | output | 8 | Recovered channel byte |
| chanOut | output | clog2(NUM_CHANNELS*8)-3 | Index of the channel in `byteOut` |
| byteValid | output | 1 | One-cycle strobe marking a new byte |
| cfgErr | output | 1 | The last write was refused |

## Verification
The bench builds the block with `NUM_CHANNELS` = 4. A frame is then 32 bit cells, or 128 oversampling cycles, long. This lets each scenario cover two full frames and cross a frame boundary several times. The frame-boundary wrap at the largest delay is therefore exercised quickly.

The serial pattern changes value within a bit cell, so each of the four quarter codes produces a different byte. The bench predicts the exact cycle of every valid strobe from the delay and the quarter. In fast mode, the bench replays the stream after a refused write, which shows at the outputs that the previous setting is still in force.

// File: rtl/tdm_in_pkg.sv
package tdm_in_pkg;

  localparam int DLY_LSB = 6;
  localparam int SMP_LSB = 4;

  typedef struct packed {
    logic sample;
    logic lastBit;
  } strobe_t;

  function automatic logic [1:0] quarterOf(input logic [1:0] code);
    case (code)
      2'b01:   quarterOf = 2'd0;
      2'b10:   quarterOf = 2'd1;
      2'b00:   quarterOf = 2'd2;
      default: quarterOf = 2'd3;
    endcase
  endfunction

  function automatic logic codeFastLegal(input logic [1:0] code);
    codeFastLegal = (code == 2'b10) || (code == 2'b11);
  endfunction

endpackage

// File: rtl/tdm_in_ctrl.sv
module tdm_in_ctrl
  import tdm_in_pkg::*;
#(
  parameter int NUM_CHANNELS = 32,
  parameter int CTRL_W = 16,
  localparam int FRAME_BITS = NUM_CHANNELS * 8,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int CHAN_W = POS_W - 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              framePulse,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              fastMode,
  output strobe_t           strb,
  output logic [CHAN_W-1:0] chan,
  output logic [2:0]        cfgDelay,
  output logic [1:0]        cfgCode,
  output logic              cfgErr
);

  localparam int CNT_W = POS_W + 2;
  localparam int FRAME_CLKS = FRAME_BITS * 4;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] posNow;
  logic [POS_W-1:0] bitIdx;
  logic [1:0]       phase;
  logic [POS_W:0]   relSum;
  logic [POS_W-1:0] rel;
  logic             locked;
  logic             lockedNow;
  logic             started;
  logic             sampleNow;
  logic [1:0]       wrCode;
  logic             reject;

  assign posNow = framePulse ? '0 : cnt;
  assign bitIdx = posNow[CNT_W-1:2];
  assign phase  = posNow[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (posNow == CNT_W'(FRAME_CLKS - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= posNow + CNT_W'(1);
    end
  end

  always_comb begin
    relSum = {1'b0, bitIdx} + (POS_W+1)'(FRAME_BITS) - {{(POS_W-2){1'b0}}, cfgDelay};
    if (relSum >= (POS_W+1)'(FRAME_BITS)) begin
      relSum = relSum - (POS_W+1)'(FRAME_BITS);
    end
    rel = relSum[POS_W-1:0];
  end

  assign lockedNow = locked | framePulse;
  assign sampleNow = lockedNow && (phase == quarterOf(cfgCode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked  <= 1'b0;
      started <= 1'b0;
    end else begin
      if (framePulse) locked <= 1'b1;
      if (sampleNow && rel[2:0] == 3'd0) started <= 1'b1;
    end
  end

  assign strb.sample  = sampleNow;
  assign strb.lastBit = sampleNow && started && (rel[2:0] == 3'd7);
  assign chan         = rel[POS_W-1:3];

  assign wrCode = ctrlWord[SMP_LSB +: 2];
  assign reject = fastMode && !codeFastLegal(wrCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDelay <= 3'd0;
      cfgCode  <= 2'b00;
      cfgErr   <= 1'b0;
    end else if (ctrlWr) begin
      if (reject) begin
        cfgErr <= 1'b1;
      end else begin
        cfgDelay <= ctrlWord[DLY_LSB +: 3];
        cfgCode  <= wrCode;
        cfgErr   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tdm_in_dpath.sv
module tdm_in_dpath
  import tdm_in_pkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdIn,
  input  strobe_t           strb,
  input  logic [CHAN_W-1:0] chan,
  output logic [7:0]        byteOut,
  output logic [CHAN_W-1:0] chanOut,
  output logic              byteValid
);

  logic [7:0] shiftReg;
  logic [7:0] shiftNext;

  assign shiftNext = {shiftReg[6:0], sdIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      byteOut   <= '0;
      chanOut   <= '0;
      byteValid <= 1'b0;
    end else begin
      if (strb.sample) shiftReg <= shiftNext;
      if (strb.lastBit) begin
        byteOut <= shiftNext;
        chanOut <= chan;
      end
      byteValid <= strb.lastBit;
    end
  end

endmodule

// File: rtl/tdm_in_sampler.sv
module tdm_in_sampler
  import tdm_in_pkg::*;
#(
  parameter int NUM_CHANNELS = 32,
  parameter int CTRL_W = 16,
  localparam int CHAN_W = $clog2(NUM_CHANNELS * 8) - 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              framePulse,
  input  logic              sdIn,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              fastMode,
  output logic [7:0]        byteOut,
  output logic [CHAN_W-1:0] chanOut,
  output logic              byteValid,
  output logic              cfgErr
);

  strobe_t           strb;
  logic [CHAN_W-1:0] chan;
  logic [2:0]        cfgDelay;
  logic [1:0]        cfgCode;

  tdm_in_ctrl #(.NUM_CHANNELS(NUM_CHANNELS), .CTRL_W(CTRL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .ctrlWr(ctrlWr),
    .ctrlWord(ctrlWord), .fastMode(fastMode), .strb(strb), .chan(chan),
    .cfgDelay(cfgDelay), .cfgCode(cfgCode), .cfgErr(cfgErr)
  );

  tdm_in_dpath #(.CHAN_W(CHAN_W)) dpath_i (
    .clk(clk), .rstN(rstN), .sdIn(sdIn), .strb(strb), .chan(chan),
    .byteOut(byteOut), .chanOut(chanOut), .byteValid(byteValid)
  );

endmodule

// File: rtl/tdm_in_chk.sv
module tdm_in_chk #(
  parameter int NUM_CHANNELS = 32,
  parameter int CTRL_W = 16,
  parameter int CHAN_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              framePulse,
  input logic              ctrlWr,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic              fastMode,
  input logic [CHAN_W-1:0] chanOut,
  input logic              byteValid,
  input logic              cfgErr,
  input logic [2:0]        cfgDelay,
  input logic [1:0]        cfgCode
);

  logic seenPulse;
  logic badWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenPulse <= 1'b0;
    else if (framePulse) seenPulse <= 1'b1;
  end

  assign badWrite = ctrlWr && fastMode &&
                    (ctrlWord[5:4] == 2'b01 || ctrlWord[5:4] == 2'b00);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid); // R5

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (int'(chanOut) < NUM_CHANNELS)); // R5

  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !seenPulse |-> !byteValid); // R6

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    badWrite |=> cfgErr); // R7

  AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    badWrite |=> ($stable(cfgDelay) && $stable(cfgCode))); // R7

  AST_ACCEPT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !badWrite) |=> (!cfgErr && cfgDelay == $past(ctrlWord[8:6])
                               && cfgCode == $past(ctrlWord[5:4]))); // R8

endmodule

bind tdm_in_sampler tdm_in_chk #(
  .NUM_CHANNELS(NUM_CHANNELS), .CTRL_W(CTRL_W), .CHAN_W(CHAN_W)
) chk_i (
  .clk(clk), .rstN(rstN), .framePulse(framePulse), .ctrlWr(ctrlWr),
  .ctrlWord(ctrlWord), .fastMode(fastMode), .chanOut(chanOut),
  .byteValid(byteValid), .cfgErr(cfgErr), .cfgDelay(cfgDelay),
  .cfgCode(cfgCode)
);

// File: tb/tdm_in_sampler_tb.sv
module tdm_in_sampler_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW = 16;
  localparam int FRAME_CELLS = NCH * 8;
  localparam int FRAME_CLKS = FRAME_CELLS * 4;
  localparam int CHW = $clog2(NCH * 8) - 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic framePulse = 1'b0;
  logic sdIn = 1'b0;
  logic ctrlWr = 1'b0;
  logic [CW-1:0] ctrlWord = '0;
  logic fastMode = 1'b0;
  logic [7:0] byteOut;
  logic [CHW-1:0] chanOut;
  logic byteValid;
  logic cfgErr;

  int nTests = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_in_sampler #(.NUM_CHANNELS(NCH), .CTRL_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .sdIn(sdIn),
    .ctrlWr(ctrlWr), .ctrlWord(ctrlWord), .fastMode(fastMode),
    .byteOut(byteOut), .chanOut(chanOut), .byteValid(byteValid),
    .cfgErr(cfgErr)
  );

  function automatic logic pat(input int t);
    int unsigned h;
    h = int'(t) * 32'h9E3779B1 + 32'h1234567;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return h[11];
  endfunction

  function automatic int quarterFor(input logic [1:0] code);
    case (code)
      2'b01: return 0;
      2'b10: return 1;
      2'b00: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    framePulse = 1'b0; sdIn = 1'b0; ctrlWr = 1'b0; ctrlWord = '0; fastMode = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeCtrl(input logic [2:0] d, input logic [1:0] code,
                           input logic [CW-1:0] junk);
    @(negedge clk);
    ctrlWord = (junk & ~16'h01F0) | {7'd0, d, code, 4'd0};
    ctrlWr = 1'b1;
    @(negedge clk);
    ctrlWr = 1'b0;
    ctrlWord = '0;
  endtask

  task automatic runStream(input int d, input logic [1:0] code, input int nOut,
                           input string req);
    int q = quarterFor(code);
    int got = 0;
    for (int cy = 0; cy < 2000 && got < nOut; cy++) begin
      @(negedge clk);
      if (cy == 0) check(byteValid == 1'b0, "R6", "valid at stream start", byteValid, 0);
      if (byteValid) begin
        int fr = got / NCH;
        int ch = got % NCH;
        int base = fr * FRAME_CELLS + ch * 8 + d;
        logic [7:0] expB;
        for (int k = 0; k < 8; k++) expB[7-k] = pat((base + k) * 4 + q);
        check(byteOut == expB, req, "byte", byteOut, expB);
        check(int'(chanOut) == ch, "R5", "channel index", chanOut, ch);
        check(cy == (base + 7) * 4 + q + 1, "R5", "valid cycle", cy, (base + 7) * 4 + q + 1);
        got++;
      end
      sdIn = pat(cy);
      framePulse = (cy % FRAME_CLKS) == 0;
    end
    check(got == nOut, req, "bytes received", got, nOut);
    framePulse = 1'b0;
    sdIn = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    check(byteValid == 1'b0, "R1", "valid after reset", byteValid, 0);
    check(cfgErr == 1'b0, "R1", "cfgErr after reset", cfgErr, 0);
  endtask

  task automatic tDefault();
    doReset();
    runStream(0, 2'b00, 2 * NCH, "R1");
  endtask

  task automatic tNoPulse();
    int seen = 0;
    doReset();
    for (int cy = 0; cy < 3 * FRAME_CLKS; cy++) begin
      @(negedge clk);
      if (byteValid) seen++;
      sdIn = pat(cy);
    end
    check(seen == 0, "R6", "valid without frame pulse", seen, 0);
  endtask

  task automatic tDelayHalf();
    doReset();
    writeCtrl(3'd3, 2'b10, 16'hFE0F);
    runStream(3, 2'b10, 2 * NCH, "R3");
  endtask

  task automatic tWrap();
    doReset();
    writeCtrl(3'd7, 2'b11, 16'h0000);
    runStream(7, 2'b11, 2 * NCH, "R4");
  endtask

  task automatic tQuarter();
    doReset();
    writeCtrl(3'd5, 2'b01, 16'h0000);
    runStream(5, 2'b01, 2 * NCH, "R2");
  endtask

  task automatic tFast();
    doReset();
    fastMode = 1'b1;
    writeCtrl(3'd2, 2'b10, 16'h0000);
    check(cfgErr == 1'b0, "R8", "cfgErr after legal write", cfgErr, 0);
    writeCtrl(3'd6, 2'b00, 16'h0000);
    check(cfgErr == 1'b1, "R7", "cfgErr after code 00", cfgErr, 1);
    writeCtrl(3'd4, 2'b01, 16'h0000);
    check(cfgErr == 1'b1, "R7", "cfgErr after code 01", cfgErr, 1);
    runStream(2, 2'b10, NCH, "R7");
    doReset();
    fastMode = 1'b1;
    writeCtrl(3'd1, 2'b00, 16'h0000);
    check(cfgErr == 1'b1, "R7", "cfgErr refused from reset", cfgErr, 1);
    writeCtrl(3'd1, 2'b11, 16'h0000);
    check(cfgErr == 1'b0, "R8", "cfgErr cleared", cfgErr, 0);
    runStream(1, 2'b11, NCH, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nTests++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    tReset();
    tDefault();
    tNoPulse();
    tDelayHalf();
    tWrap();
    tQuarter();
    tFast();
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule